// File: doc/BRIEF.md
# Link ACK/NACK Retransmission Buffer

This block holds both ends of a single point-to-point flit link that recovers from errors with positive and negative acknowledgements. The sending end writes each accepted flit into a small replay store. It puts flits onto the wire as soon as they are stored, without waiting for any report of space at the far end, and it keeps every copy until that flit is acknowledged. The receiving end checks each arriving flit. It answers on the next clock edge with an ACK or a NACK, and the answer carries the tag of the flit it expects next.

A parity error, or a tag that is out of sequence, makes the receiver drop the flit and send a NACK. The sender then rewinds to the oldest unacknowledged copy and replays the window in its original order. Only flits that passed both checks appear at the delivery port, in the order they were accepted, each exactly once. A retransmit timer covers the case where the last flit in flight is lost and no later flit exists to expose the gap. The wire between the two ends passes through two fault points, a drop control and a bit-flip control, which model a lossy channel.

Top module: `arq_link_top`

## Requirements
- R1: `in_ready` is high whenever fewer than DEPTH (default 8) copies are unacknowledged. A flit is taken on a rising edge where both `in_valid` and `in_ready` are high.
- R2: The sender does not wait for any status from the receiver. On a clean link, a flit accepted on edge k goes onto the wire at edge k+1 and appears on `out_valid`/`out_data` after edge k+2.
- R3: At most DEPTH copies are held. With DEPTH unacknowledged, `in_ready` is low, and a flit offered while it is low is ignored and never delivered.
- R4: Each copy stays in the replay store until its ACK arrives, and that ACK frees exactly that one slot.
- R5: The receiver answers every flit that arrives on the edge after its arrival, with a 3-bit tag equal to its expected sequence number. The sender acts on the answer at the following edge, so an isolated flit's slot is free again at edge k+3 after acceptance on edge k.
- R6: The wire carries an even-parity bit equal to the XOR of the 20 data bits. A flit whose data and parity bit XOR to 1 is not delivered and draws a NACK.
- R7: When a NACK names the oldest copy, the sender skips one transmit slot and then replays from that copy in original order. A flit corrupted at its arrival edge j reappears on `out_valid` after edge j+3.
- R8: The receiver drops a flit whose tag is not its expected tag and NACKs it. A NACK that arrives on the cycle right after a rewind is ignored.
- R9: If sent copies are outstanding and no answer arrives for RTO_CYCLES (default 16) consecutive cycles, the sender rewinds and replays from the oldest copy.
- R10: Synchronous active-low reset empties the replay store and sets both the send tag and the expected tag to zero. After reset `in_ready` is high, `out_valid` is low, and nothing accepted before the reset is delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A flit is offered to the sender |
| in_data | input | 20 | Offered flit payload |
| in_ready | output | 1 | Replay store has a free slot |
| link_drop | input | 1 | Channel fault: the flit on the wire this cycle is lost |
| link_flip | input | 1 | Channel fault: data bit 0 of the flit on the wire this cycle is inverted |
| out_valid | output | 1 | A checked, in-sequence flit is delivered this cycle |
| out_data | output | 20 | Delivered flit payload |

## Verification
The sender can take a new flit into the tail of the replay store on the same edge that a NACK rewinds its read pointer to the head. The same holds for a flit accepted on an edge where a late ACK frees the head copy during a replay. Both cases are provoked by offering a flit on every cycle while short drops and single-bit flips are injected at pseudo-random points. A reference queue of accepted flits is compared against every delivery, so a flit lost, duplicated or reordered by a clash between writing and rewinding shows up as a mismatch. Directed cases pin the exact edge of the first delivery, the replay after a flip and the replay after a drop, and the edge at which the slot freed by an ACK becomes visible on `in_ready`.

// File: rtl/arq_pkg.sv
// Shared definitions for the ACK/NACK link.
// Assumes: one answer per cycle travels from receiver to sender.
package arq_pkg;

    // Kind of answer returned on the reverse path.
    typedef enum logic {
        RSP_ACK  = 1'b0,
        RSP_NACK = 1'b1
    } rsp_kind_e;

endpackage

// File: rtl/arq_channel.sv
// Wire model between the two ends: it passes the flit through, except that
// it can drop it or flip data bit 0 for one cycle.
// Assumes: purely combinational, both faults apply to the current cycle.
module arq_channel #(
    parameter int DATA_W = 20,
    parameter int TAG_W  = 3
) (
    input  logic              tx_valid,
    input  logic [TAG_W-1:0]  tx_tag,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_par,
    input  logic              link_drop,
    input  logic              link_flip,
    output logic              rx_valid,
    output logic [TAG_W-1:0]  rx_tag,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_par
);

    localparam logic [DATA_W-1:0] FLIP_MASK = DATA_W'(1);

    // Apply the channel faults to the flit on the wire.
    always_comb begin
        rx_valid = tx_valid & ~link_drop;
        rx_tag   = tx_tag;
        rx_data  = link_flip ? (tx_data ^ FLIP_MASK) : tx_data;
        rx_par   = tx_par;
    end

endmodule

// File: rtl/arq_link_rx.sv
// Receiving end: it checks each flit for parity and sequence, and it delivers
// only good flits that arrive in order. Each arrival draws a registered
// ACK or NACK that carries the expected tag.
// Assumes: there is no back-pressure on delivery.
module arq_link_rx
    import arq_pkg::*;
#(
    parameter int DATA_W = 20,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_valid,
    input  logic [TAG_W-1:0]  link_tag,
    input  logic [DATA_W-1:0] link_data,
    input  logic              link_par,
    output logic              rsp_valid,
    output rsp_kind_e         rsp_kind,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic [TAG_W-1:0] exp_tag;
    logic             par_ok;
    logic             in_seq;
    logic             good;

    // Classify the arriving flit.
    always_comb begin
        par_ok = ((^link_data) == link_par);
        in_seq = (link_tag == exp_tag);
        good   = link_valid && par_ok && in_seq;
    end

    // Register the answer, the delivery and the next expected tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_kind  <= RSP_ACK;
            rsp_tag   <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            exp_tag   <= '0;
        end else begin
            rsp_valid <= link_valid;
            out_valid <= good;
            if (link_valid) begin
                rsp_kind <= good ? RSP_ACK : RSP_NACK;
                rsp_tag  <= exp_tag;
            end
            if (good) begin
                out_data <= link_data;
                exp_tag  <= exp_tag + TAG_W'(1);
            end
        end
    end

    // R6: a delivered flit had matching parity on the wire.
    a_r6_only_clean_delivered: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(^link_data) == $past(link_par)));

    // R8: the expected tag advances by one per delivery.
    a_r8_tag_advances: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (exp_tag == $past(exp_tag) + TAG_W'(1)));

    // R8: a dropped or absent flit leaves the expected tag unchanged.
    a_r8_tag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(exp_tag));

endmodule

// File: rtl/arq_replay_tx.sv
// Sending end: a replay store of DEPTH copies with head (oldest unacked),
// send (next to transmit) and tail (next free) pointers. It rewinds to the
// head on a NACK for the head or on a retransmit timeout.
// Assumes: DEPTH is a power of two, and the tag is the low bits of a pointer.
module arq_replay_tx
    import arq_pkg::*;
#(
    parameter int DATA_W     = 20,
    parameter int DEPTH      = 8,
    parameter int TAG_W      = 3,
    parameter int RTO_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              tx_valid,
    output logic [TAG_W-1:0]  tx_tag,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_par,
    input  logic              rsp_valid,
    input  rsp_kind_e         rsp_kind,
    input  logic [TAG_W-1:0]  rsp_tag
);

    localparam int               PTR_W    = TAG_W + 1;
    localparam int               TMR_W    = $clog2(RTO_CYCLES + 1);
    localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(RTO_CYCLES - 1);

    logic [PTR_W-1:0]  head_q, send_q, tail_q;
    logic [PTR_W-1:0]  used, inflight, eff_send;
    logic [TMR_W-1:0]  idle_q;
    logic              hold_q;
    logic              wr_go, ack_take, nack_take, timeout_fire, rewind, send_go;
    logic [DATA_W-1:0] slot_rd [DEPTH];
    logic [DATA_W-1:0] pick;

    // One storage slot per copy, written when the tail points at it.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic [DATA_W-1:0] data_q;
        // Capture an accepted flit into this slot.
        always_ff @(posedge clk) begin
            if (wr_go && (tail_q[TAG_W-1:0] == TAG_W'(s))) begin
                data_q <= in_data;
            end
        end
        assign slot_rd[s] = data_q;
    end

    // Occupancy, answer decoding, rewind and transmit selection.
    always_comb begin
        used         = tail_q - head_q;
        inflight     = send_q - head_q;
        in_ready     = (used != FULL_CNT);
        wr_go        = in_valid && in_ready;
        ack_take     = rsp_valid && (rsp_kind == RSP_ACK) &&
                       (rsp_tag == head_q[TAG_W-1:0]) && (used != '0);
        nack_take    = rsp_valid && (rsp_kind == RSP_NACK) && !hold_q &&
                       (rsp_tag == head_q[TAG_W-1:0]) && (used != '0);
        timeout_fire = (inflight != '0) && !rsp_valid && (idle_q == TMR_LAST);
        rewind       = nack_take || timeout_fire;
        if (rewind) begin
            eff_send = head_q;
        end else if (ack_take && (send_q == head_q)) begin
            eff_send = head_q + PTR_W'(1);
        end else begin
            eff_send = send_q;
        end
        send_go = !rewind && (eff_send != tail_q);
        pick    = slot_rd[eff_send[TAG_W-1:0]];
    end

    // Advance the three pointers and the one-cycle NACK ignore flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            send_q <= '0;
            tail_q <= '0;
            hold_q <= 1'b0;
        end else begin
            head_q <= ack_take ? head_q + PTR_W'(1) : head_q;
            tail_q <= wr_go ? tail_q + PTR_W'(1) : tail_q;
            send_q <= send_go ? eff_send + PTR_W'(1) : eff_send;
            hold_q <= rewind;
        end
    end

    // Count silent cycles while sent copies wait for an answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (rsp_valid || (inflight == '0) || rewind) begin
            idle_q <= '0;
        end else begin
            idle_q <= idle_q + TMR_W'(1);
        end
    end

    // Drive the outgoing flit register with its tag and even parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_tag   <= '0;
            tx_data  <= '0;
            tx_par   <= 1'b0;
        end else begin
            tx_valid <= send_go;
            if (send_go) begin
                tx_tag  <= eff_send[TAG_W-1:0];
                tx_data <= pick;
                tx_par  <= ^pick;
            end
        end
    end

    // R3: the store never holds more than DEPTH copies.
    a_r3_used_within_depth: assert property (@(posedge clk) disable iff (!rst_n)
        used <= FULL_CNT);

    // R5: an ACK always names the oldest held copy.
    a_r5_ack_names_head: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_kind == RSP_ACK)) |-> ((rsp_tag == head_q[TAG_W-1:0]) && (used != '0)));

    // R2: unsent copies go out on the next edge when no answer intervenes.
    a_r2_send_without_credit: assert property (@(posedge clk) disable iff (!rst_n)
        ((send_q != tail_q) && !rsp_valid && !timeout_fire) |=> tx_valid);

endmodule

// File: rtl/arq_link_top.sv
// One ACK/NACK protected link: the sending end, the fault-injecting wire
// and the receiving end, with the answer path fed back to the sender.
// Assumes: DEPTH is a power of two, so each tag names one replay slot.
module arq_link_top
    import arq_pkg::*;
#(
    parameter int DATA_W     = 20,
    parameter int DEPTH      = 8,
    parameter int RTO_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              link_drop,
    input  logic              link_flip,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam int TAG_W = $clog2(DEPTH);

    logic              tx_valid, rx_valid, tx_par, rx_par, rsp_valid;
    logic [TAG_W-1:0]  tx_tag, rx_tag, rsp_tag;
    logic [DATA_W-1:0] tx_data, rx_data;
    rsp_kind_e         rsp_kind;

    arq_replay_tx #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .TAG_W(TAG_W), .RTO_CYCLES(RTO_CYCLES)
    ) u_tx (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .tx_valid(tx_valid), .tx_tag(tx_tag), .tx_data(tx_data), .tx_par(tx_par),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_tag(rsp_tag)
    );

    arq_channel #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_wire (
        .tx_valid(tx_valid), .tx_tag(tx_tag), .tx_data(tx_data), .tx_par(tx_par),
        .link_drop(link_drop), .link_flip(link_flip),
        .rx_valid(rx_valid), .rx_tag(rx_tag), .rx_data(rx_data), .rx_par(rx_par)
    );

    arq_link_rx #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .link_valid(rx_valid), .link_tag(rx_tag), .link_data(rx_data), .link_par(rx_par),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_tag(rsp_tag),
        .out_valid(out_valid), .out_data(out_data)
    );

endmodule

// File: tb/arq_link_top_test.sv
// Bench: a queue of accepted flits is the reference model; every delivery is
// compared against its head on each clock, and directed cases pin edges.
module arq_link_top_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DW = 20;

    logic          clk       = 1'b0;
    logic          rst_n     = 1'b0;
    logic          in_valid  = 1'b0;
    logic [DW-1:0] in_data   = '0;
    logic          link_drop = 1'b0;
    logic          link_flip = 1'b0;
    logic          in_ready;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int checks    = 0;
    int errors    = 0;
    int delivered = 0;
    logic [DW-1:0] owed [$];

    always #2.5 clk = ~clk;

    arq_link_top uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .link_drop(link_drop), .link_flip(link_flip),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference model: each delivery must equal the oldest accepted flit.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            delivered++;
            checks++;
            if (owed.size() == 0) begin
                errors++;
                $display("FAIL R3: unexpected delivery actual %05h expected none", out_data);
            end else begin
                if (out_data !== owed[0]) begin
                    errors++;
                    $display("FAIL R7: delivery order actual %05h expected %05h", out_data, owed[0]);
                end
                void'(owed.pop_front());
            end
        end
    end

    // Offer one flit for one edge; called and returning just after a falling edge.
    task automatic offer(input logic [DW-1:0] d, output bit took);
        in_valid = 1'b1;
        in_data  = d;
        took     = in_ready;
        if (took) owed.push_back(d);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input string req, input int limit);
        int n = 0;
        while (owed.size() != 0 && n < limit) begin
            @(negedge clk);
            n++;
        end
        idle(2);
        chk(owed.size() == 0, req, "flits still owed", owed.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit t;
        logic [15:0] lfsr;
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 / R10: state right after reset.
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);

        // R2: clean latency, delivery after the second edge.
        offer(20'h1A001, t);
        chk(t, "R1", "flit accepted when ready", t, 1);
        chk(out_valid == 1'b0, "R2", "out_valid one edge early", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R2", "out_valid at edge k+1", out_valid, 0);
        @(negedge clk);
        chk(out_valid && out_data == 20'h1A001, "R2", "delivery at edge k+2", out_data, 20'h1A001);
        idle(10);

        // R4 / R5 / R3: the first ACK frees its slot, then the store fills.
        offer(20'h2B000, t);
        offer(20'h2B001, t);
        offer(20'h2B002, t);
        link_drop = 1'b1;
        for (int i = 3; i < 8; i++) offer(20'h2B000 + DW'(i), t);
        chk(in_ready == 1'b1, "R4", "slot freed by first ACK (R5 timing)", in_ready, 1);
        offer(20'h2B008, t);
        chk(t, "R4", "ninth flit taken after free", t, 1);
        chk(in_ready == 1'b0, "R3", "in_ready with 8 unacked", in_ready, 0);
        begin
            int took_n = 0;
            for (int i = 0; i < 5; i++) begin
                offer(20'hDEAD0 + DW'(i), t);
                if (t) took_n++;
            end
            chk(took_n == 0, "R3", "flits taken while full", took_n, 0);
        end
        link_drop = 1'b0;
        // R9: only the retransmit timer can recover these.
        drain("R9", 300);
        base = delivered;
        idle(40);
        chk(delivered == base, "R3", "ignored flit delivered", delivered - base, 0);

        // R6 / R7: a single flipped flit is held back, then replayed.
        offer(20'h3C0C3, t);
        @(negedge clk);
        link_flip = 1'b1;
        @(negedge clk);
        link_flip = 1'b0;
        chk(out_valid == 1'b0, "R6", "corrupted flit delivered", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", "out_valid during rewind", out_valid, 0);
        @(negedge clk);
        @(negedge clk);
        chk(out_valid && out_data == 20'h3C0C3, "R7", "replayed flit three edges later", out_data, 20'h3C0C3);
        idle(10);

        // R8 / R7: first of two flits lost, second dropped, both replayed in order.
        offer(20'h4D001, t);
        offer(20'h4D002, t);
        link_drop = 1'b1;
        @(negedge clk);
        link_drop = 1'b0;
        chk(out_valid == 1'b0, "R8", "lost flit slot", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", "out-of-sequence flit delivered", out_valid, 0);
        idle(3);
        chk(out_valid && out_data == 20'h4D001, "R7", "first replayed flit", out_data, 20'h4D001);
        @(negedge clk);
        chk(out_valid && out_data == 20'h4D002, "R7", "second replayed flit", out_data, 20'h4D002);
        idle(10);

        // R6: stream with periodic single-bit flips.
        for (int i = 0; i < 60; i++) begin
            link_flip = (i % 7 == 3);
            offer(20'h50000 + DW'(i), t);
        end
        link_flip = 1'b0;
        drain("R6", 400);

        // R8: stream with periodic one-cycle drops.
        for (int i = 0; i < 60; i++) begin
            link_drop = (i % 9 == 4);
            offer(20'h60000 + DW'(i), t);
        end
        link_drop = 1'b0;
        drain("R8", 400);

        // R7: pseudo-random mix of both faults under continuous offers.
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            link_flip = (lfsr[3:0] == 4'h0);
            link_drop = (lfsr[7:4] == 4'h1);
            offer(20'h70000 + DW'(i), t);
        end
        link_flip = 1'b0;
        link_drop = 1'b0;
        drain("R7", 2000);

        // R10: reset with copies outstanding discards them.
        link_drop = 1'b1;
        for (int i = 0; i < 3; i++) offer(20'h8E000 + DW'(i), t);
        idle(2);
        rst_n = 1'b0;
        owed.delete();
        idle(3);
        rst_n     = 1'b1;
        link_drop = 1'b0;
        chk(in_ready == 1'b1, "R10", "in_ready after mid-run reset", in_ready, 1);
        chk(out_valid == 1'b0, "R10", "out_valid after mid-run reset", out_valid, 0);
        base = delivered;
        idle(40);
        chk(delivered == base, "R10", "stale flits delivered", delivered - base, 0);
        offer(20'h9F001, t);
        offer(20'h9F002, t);
        drain("R10", 50);
        chk(delivered == base + 2, "R10", "flits delivered after reset", delivered - base, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule